// File: doc/BRIEF.md
# Link Speed Fallback Retrain Sequencer

This controller decides whether a downstream-facing PCIe port needs manual link speed recovery, and if it does, lowers the target link speed one step at a time with a retrain at each step. When `start_i` is high, it samples snapshots of the port's capability flags word, its maximum supported speed code, its supported-speed vector, its link status word and its current link-control-2 value. It then decides whether to act. If it acts, it asks an external stability monitor for a verdict through a start/done/stable handshake.

When the first verdict is unstable, the controller clears the target-speed field in a link-control-2 shadow register. It then walks the candidate speeds downward. For each candidate that the port supports, it writes the new target speed into the shadow, pulses a retrain request, and asks the monitor again. It stops at the first stable verdict. The block finishes with one of four result codes, and its outputs hold until the next start.

Top module: `link_speed_fallback_seq`

## Requirements
- R1: When the capability version (flags bits [3:0]) is below 2, the run is skipped. Skipped means result 0, speed 0, the shadow equals `lctl2_i`, and no monitor request, write or retrain occurs.
- R2: The run proceeds only when the port type (flags bits [7:4]) is 4, 6 or 8. Any other type gives a skip.
- R3: When the maximum speed code `sls_i` is 1 or lower, the run is skipped.
- R4: The run proceeds only when link status bit 14 is set and link status bit 13 is clear. Otherwise it is skipped.
- R5: An eligible run first requests one stability check. If that check reports stable, the result is 1, the speed is 0 and the shadow equals `lctl2_i`.
- R6: After an unstable first check, the shadow bits [3:0] are cleared and the other bits are kept. Candidates are then tried in the order `sls_i`-1 down to 1, with speed codes 1 = 2.5, 2 = 5.0 and 3 = 8.0 GT/s.
- R7: When `spd_vec_i` is nonzero and its bit at a candidate's code is 0, that candidate is passed over with no write. A zero vector allows every candidate.
- R8: For each candidate, `lctl2_wr_o` pulses for one cycle with the new value on `lctl2_o`. `retrain_o` pulses in the next cycle, and `mon_start_o` pulses in the cycle after that.
- R9: The first candidate whose check is stable ends the run with result 2 and `speed_o` equal to that candidate.
- R10: When no candidate is stable, or no candidate is allowed, the result is 3 and the speed is 0. The shadow keeps the last written speed, or 0 if no speed was written.
- R11: For an eligible run, `busy_o` is high from the cycle after the start until `done_o` rises, and `done_o` is low during that time. A skip posts `done_o` in the cycle after the start, with `busy_o` low.
- R12: Once a run is done, `result_o`, `speed_o`, `lctl2_o` and `done_o` hold their values and no pulses occur until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run; sampled only when idle |
| cap_flags_i | input | 16 | Capability flags word snapshot |
| sls_i | input | 4 | Maximum supported speed code |
| spd_vec_i | input | 16 | Supported-speed vector, bit n for code n |
| lnk_sta_i | input | 16 | Link status word snapshot |
| lctl2_i | input | 16 | Current link-control-2 value |
| mon_start_o | output | 1 | One-cycle request to the stability monitor |
| mon_done_i | input | 1 | Monitor verdict valid |
| mon_stable_i | input | 1 | Monitor verdict: link stable |
| lctl2_wr_o | output | 1 | One-cycle write strobe for the shadow value |
| retrain_o | output | 1 | One-cycle retrain-link request |
| lctl2_o | output | 16 | Link-control-2 shadow |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Result valid |
| result_o | output | 2 | 0 skipped, 1 already stable, 2 recovered, 3 exhausted |
| speed_o | output | 4 | Recovered speed code, else 0 |

## Verification
A skip decision is due in the cycle after the start edge. The bench samples it at the first falling edge after the start and also confirms `busy_o` there for eligible runs. The write, retrain and monitor pulses each follow the previous one by exactly one cycle, so a recorder running on every falling edge checks each pulse against the one seen one falling edge earlier. The final result is due one cycle after the last monitor verdict, so the bench waits for `done_o` on falling edges and then compares the result, speed, shadow value, write log and pulse counts with its model. It then checks three more falling edges for held values.

// File: rtl/lsf_pkg.sv
package lsf_pkg;
    localparam int FLAG_VER_LSB  = 0;
    localparam int FLAG_TYPE_LSB = 4;
    localparam int STA_DLACT_BIT = 13;
    localparam int STA_BWCHG_BIT = 14;

    localparam logic [3:0] PTYPE_ROOT   = 4'd4;
    localparam logic [3:0] PTYPE_DOWN   = 4'd6;
    localparam logic [3:0] PTYPE_BRIDGE = 4'd8;

    typedef enum logic [1:0] {
        RES_SKIP      = 2'd0,
        RES_ASIS      = 2'd1,
        RES_RECOVERED = 2'd2,
        RES_EXHAUSTED = 2'd3
    } lsf_result_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_PICK,
        ST_RETRAIN,
        ST_MONST
    } lsf_state_e;
endpackage

// File: rtl/lsf_gate.sv
module lsf_gate
    import lsf_pkg::*;
#(
    parameter int SPD_W   = 4,
    parameter int MIN_VER = 2
) (
    input  logic [15:0]      flags_i,
    input  logic [SPD_W-1:0] max_spd_i,
    input  logic [15:0]      sta_i,
    output logic             ok_o
);
    logic [3:0] ver;
    logic [3:0] ptype;
    logic       ver_ok;
    logic       type_ok;
    logic       spd_ok;
    logic       sta_ok;

    always_comb begin
        ver     = flags_i[FLAG_VER_LSB +: 4];
        ptype   = flags_i[FLAG_TYPE_LSB +: 4];
        ver_ok  = (32'(ver) >= MIN_VER);
        type_ok = (ptype == PTYPE_ROOT) || (ptype == PTYPE_DOWN) ||
                  (ptype == PTYPE_BRIDGE);
        spd_ok  = (max_spd_i > SPD_W'(1));
        sta_ok  = sta_i[STA_BWCHG_BIT] && !sta_i[STA_DLACT_BIT];
        ok_o    = ver_ok && type_ok && spd_ok && sta_ok;
    end
endmodule

// File: rtl/lsf_cand_sel.sv
module lsf_cand_sel #(
    parameter int SPD_W = 4,
    localparam int VEC_W = 1 << SPD_W
) (
    input  logic [SPD_W-1:0] cand_i,
    input  logic [VEC_W-1:0] vec_i,
    output logic             at_end_o,
    output logic             unsup_o
);
    always_comb begin
        at_end_o = (cand_i == '0);
        unsup_o  = (vec_i != '0) && !vec_i[cand_i];
    end
endmodule

// File: rtl/lsf_tls_merge.sv
module lsf_tls_merge #(
    parameter int SPD_W = 4,
    parameter int CTL_W = 16
) (
    input  logic [CTL_W-1:0] base_i,
    input  logic [SPD_W-1:0] spd_i,
    output logic [CTL_W-1:0] merged_o
);
    always_comb begin
        merged_o              = base_i;
        merged_o[SPD_W-1:0]   = spd_i;
    end
endmodule

// File: rtl/link_speed_fallback_seq.sv
module link_speed_fallback_seq
    import lsf_pkg::*;
#(
    parameter int SPD_W   = 4,
    parameter int CTL_W   = 16,
    parameter int MIN_VER = 2,
    localparam int VEC_W  = 1 << SPD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [15:0]      cap_flags_i,
    input  logic [SPD_W-1:0] sls_i,
    input  logic [VEC_W-1:0] spd_vec_i,
    input  logic [15:0]      lnk_sta_i,
    input  logic [CTL_W-1:0] lctl2_i,
    output logic             mon_start_o,
    input  logic             mon_done_i,
    input  logic             mon_stable_i,
    output logic             lctl2_wr_o,
    output logic             retrain_o,
    output logic [CTL_W-1:0] lctl2_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [1:0]       result_o,
    output logic [SPD_W-1:0] speed_o
);
    typedef struct packed {
        lsf_state_e       st;
        logic             first;
        logic [SPD_W-1:0] cand;
        logic [VEC_W-1:0] vec;
        logic [CTL_W-1:0] lctl2;
        logic             wr;
        logic             rt;
        logic             ms;
        logic             busy;
        logic             done;
        lsf_result_e      res;
        logic [SPD_W-1:0] speed;
    } regs_t;

    regs_t r_q, r_d;

    logic             gate_ok;
    logic             cand_end;
    logic             cand_unsup;
    logic [SPD_W-1:0] merge_spd;
    logic [CTL_W-1:0] merged;

    lsf_gate #(.SPD_W(SPD_W), .MIN_VER(MIN_VER)) u_gate (
        .flags_i   (cap_flags_i),
        .max_spd_i (sls_i),
        .sta_i     (lnk_sta_i),
        .ok_o      (gate_ok)
    );

    lsf_cand_sel #(.SPD_W(SPD_W)) u_cand (
        .cand_i   (r_q.cand),
        .vec_i    (r_q.vec),
        .at_end_o (cand_end),
        .unsup_o  (cand_unsup)
    );

    assign merge_spd = (r_q.st == ST_WAIT) ? '0 : r_q.cand;

    lsf_tls_merge #(.SPD_W(SPD_W), .CTL_W(CTL_W)) u_merge (
        .base_i   (r_q.lctl2),
        .spd_i    (merge_spd),
        .merged_o (merged)
    );

    always_comb begin
        r_d    = r_q;
        r_d.wr = 1'b0;
        r_d.rt = 1'b0;
        r_d.ms = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.done  = 1'b0;
                    r_d.res   = RES_SKIP;
                    r_d.speed = '0;
                    r_d.lctl2 = lctl2_i;
                    r_d.vec   = spd_vec_i;
                    r_d.cand  = sls_i - SPD_W'(1);
                    if (gate_ok) begin
                        r_d.st    = ST_WAIT;
                        r_d.first = 1'b1;
                        r_d.ms    = 1'b1;
                        r_d.busy  = 1'b1;
                    end else begin
                        r_d.done  = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (mon_done_i) begin
                    if (mon_stable_i) begin
                        r_d.st    = ST_IDLE;
                        r_d.busy  = 1'b0;
                        r_d.done  = 1'b1;
                        r_d.res   = r_q.first ? RES_ASIS : RES_RECOVERED;
                        r_d.speed = r_q.first ? '0 : r_q.cand;
                    end else begin
                        r_d.st = ST_PICK;
                        if (r_q.first) begin
                            r_d.first = 1'b0;
                            r_d.lctl2 = merged;
                        end else begin
                            r_d.cand = r_q.cand - SPD_W'(1);
                        end
                    end
                end
            end
            ST_PICK: begin
                if (cand_end) begin
                    r_d.st   = ST_IDLE;
                    r_d.busy = 1'b0;
                    r_d.done = 1'b1;
                    r_d.res  = RES_EXHAUSTED;
                end else if (cand_unsup) begin
                    r_d.cand = r_q.cand - SPD_W'(1);
                end else begin
                    r_d.lctl2 = merged;
                    r_d.wr    = 1'b1;
                    r_d.st    = ST_RETRAIN;
                end
            end
            ST_RETRAIN: begin
                r_d.rt = 1'b1;
                r_d.st = ST_MONST;
            end
            ST_MONST: begin
                r_d.ms = 1'b1;
                r_d.st = ST_WAIT;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, res: RES_SKIP, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mon_start_o = r_q.ms;
    assign lctl2_wr_o  = r_q.wr;
    assign retrain_o   = r_q.rt;
    assign lctl2_o     = r_q.lctl2;
    assign busy_o      = r_q.busy;
    assign done_o      = r_q.done;
    assign result_o    = r_q.res;
    assign speed_o     = r_q.speed;

    AST_RETRAIN_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        retrain_o |-> $past(lctl2_wr_o)); // R8
    AST_MONSTART_AFTER_RETRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(retrain_o) |-> mon_start_o); // R8
    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lctl2_wr_o, retrain_o, mon_start_o})); // R8
    AST_WRITE_SUPPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        lctl2_wr_o |-> (r_q.vec == '0) || r_q.vec[lctl2_o[SPD_W-1:0]]); // R7
    AST_WRITE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lctl2_wr_o |-> (lctl2_o[SPD_W-1:0] != '0) && busy_o); // R6
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R11
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !busy_o) |=> $stable(result_o) && $stable(speed_o) &&
                                   $stable(lctl2_o) && $stable(done_o)); // R12
endmodule

// File: tb/link_speed_fallback_seq_tb.sv
module link_speed_fallback_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] cap_flags_i = '0;
    logic [3:0]  sls_i = '0;
    logic [15:0] spd_vec_i = '0;
    logic [15:0] lnk_sta_i = '0;
    logic [15:0] lctl2_i = '0;
    logic        mon_start_o;
    logic        mon_done_i = 1'b0;
    logic        mon_stable_i = 1'b0;
    logic        lctl2_wr_o;
    logic        retrain_o;
    logic [15:0] lctl2_o;
    logic        busy_o;
    logic        done_o;
    logic [1:0]  result_o;
    logic [3:0]  speed_o;

    link_speed_fallback_seq u_dut (
        .clk, .rst_n, .start_i, .cap_flags_i, .sls_i, .spd_vec_i, .lnk_sta_i,
        .lctl2_i, .mon_start_o, .mon_done_i, .mon_stable_i, .lctl2_wr_o,
        .retrain_o, .lctl2_o, .busy_o, .done_o, .result_o, .speed_o
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    bit          finished = 1'b0;

    // monitor model and pulse recorder
    bit [15:0]   plan = '0;
    int          mon_idx = 0;
    int          mon_wait = 0;
    int          wr_cnt = 0;
    int          rt_cnt = 0;
    int          ms_cnt = 0;
    int          order_err = 0;
    logic [3:0]  wr_log [16];
    bit          prev_wr = 1'b0;
    bit          prev_rt = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial forever begin
        @(negedge clk);
        if (mon_done_i) mon_done_i = 1'b0;
        if (lctl2_wr_o) begin
            if (wr_cnt < 16) wr_log[wr_cnt] = lctl2_o[3:0];
            wr_cnt++;
        end
        if (retrain_o) rt_cnt++;
        if (retrain_o && !prev_wr) order_err++;
        if (prev_wr && !retrain_o) order_err++;
        if (prev_rt && !mon_start_o) order_err++;
        prev_wr = lctl2_wr_o;
        prev_rt = retrain_o;
        if (mon_start_o) begin
            ms_cnt++;
            mon_wait = 1 + int'($urandom % 3);
        end else if (mon_wait > 0) begin
            mon_wait--;
            if (mon_wait == 0) begin
                mon_done_i   = 1'b1;
                mon_stable_i = (mon_idx < 16) ? plan[mon_idx] : 1'b0;
                mon_idx++;
            end
        end
    end

    task automatic run_case(input logic [15:0] flags, input logic [3:0] sls,
                            input logic [15:0] vec, input logic [15:0] sta,
                            input logic [15:0] lin, input bit [15:0] pl);
        bit         elig;
        int         e_res, e_spd, e_chk, e_wr;
        logic [15:0] e_lctl2;
        logic [3:0] e_log [16];
        logic [3:0] last;
        bit         got;
        int         guard;
        elig = (flags[3:0] >= 4'd2) &&
               (flags[7:4] == 4'd4 || flags[7:4] == 4'd6 || flags[7:4] == 4'd8) &&
               (sls > 4'd1) && sta[14] && !sta[13];
        e_res = 0; e_spd = 0; e_chk = 0; e_wr = 0; e_lctl2 = lin; last = '0;
        for (int i = 0; i < 16; i++) e_log[i] = '0;
        if (elig) begin
            e_chk = 1;
            if (pl[0]) begin
                e_res = 1;
            end else begin
                e_res = 3;
                got = 1'b0;
                for (int c = int'(sls) - 1; c >= 1; c--) begin
                    if (!got && !(vec != 0 && !vec[c])) begin
                        e_log[e_wr] = 4'(c);
                        e_wr++;
                        last = 4'(c);
                        if (pl[e_chk]) begin
                            got = 1'b1; e_res = 2; e_spd = c;
                        end
                        e_chk++;
                    end
                end
                e_lctl2 = {lin[15:4], last};
            end
        end

        @(negedge clk);
        plan = pl; mon_idx = 0; mon_wait = 0;
        wr_cnt = 0; rt_cnt = 0; ms_cnt = 0; order_err = 0;
        cap_flags_i = flags; sls_i = sls; spd_vec_i = vec; lnk_sta_i = sta; lctl2_i = lin;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (elig) begin
            chk(busy_o && !done_o, "R11 busy after eligible start", {busy_o, done_o}, 2);
        end else begin
            chk(done_o && !busy_o && result_o == 2'd0, "R1 R2 R3 R4 skip posted",
                {done_o, busy_o, result_o}, 8);
        end
        guard = 0;
        while (!done_o && guard < 2000) begin
            @(negedge clk);
            guard++;
            if (!done_o && !busy_o) begin
                chk(1'b0, "R11 busy dropped early", 0, 1);
            end
        end
        chk(int'(result_o) == e_res, "R5 R9 R10 result", result_o, e_res);
        chk(int'(speed_o) == e_spd, "R9 R10 speed", speed_o, e_spd);
        chk(lctl2_o == e_lctl2, "R6 R10 shadow", lctl2_o, e_lctl2);
        chk(wr_cnt == e_wr, "R6 R7 write count", wr_cnt, e_wr);
        for (int i = 0; i < e_wr && i < 16; i++)
            chk(wr_log[i] == e_log[i], "R6 R7 write order", wr_log[i], e_log[i]);
        chk(rt_cnt == e_wr, "R8 retrain count", rt_cnt, e_wr);
        chk(ms_cnt == e_chk, "R5 R8 monitor requests", ms_cnt, e_chk);
        chk(order_err == 0, "R8 pulse ordering", order_err, 0);
        repeat (3) @(negedge clk);
        chk(done_o && int'(result_o) == e_res && int'(speed_o) == e_spd &&
            lctl2_o == e_lctl2 && wr_cnt == e_wr && ms_cnt == e_chk,
            "R12 outputs held", {result_o, speed_o}, {e_res[1:0], e_spd[3:0]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(!done_o && !busy_o && result_o == 2'd0 && lctl2_o == 16'h0 &&
            !mon_start_o && !retrain_o && !lctl2_wr_o, "R11 reset state",
            {done_o, busy_o, result_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 version 1
        run_case(16'h0041, 4'd3, 16'h0, 16'h4000, 16'hA5A3, 16'h0);
        // R2 upstream type 5
        run_case(16'h0052, 4'd3, 16'h0, 16'h4000, 16'h1233, 16'h0);
        // R3 max speed 1
        run_case(16'h0062, 4'd1, 16'h0, 16'h4000, 16'h1231, 16'h0);
        // R4 data-link active set / bandwidth bit clear
        run_case(16'h0062, 4'd3, 16'h0, 16'h6000, 16'h1233, 16'h0);
        run_case(16'h0082, 4'd3, 16'h0, 16'h0800, 16'h1233, 16'h0);
        // R5 stable at once
        run_case(16'h0042, 4'd3, 16'h0, 16'h4800, 16'hBEE3, 16'h0001);
        // R6 R10 zero vector, all fail
        run_case(16'h0062, 4'd3, 16'h0, 16'h4000, 16'hF0F3, 16'h0000);
        // R7 R9 sparse vector, recover at code 1
        run_case(16'h0082, 4'd4, 16'h000A, 16'h4000, 16'h00C4, 16'h0004);
        // R10 vector with nothing below the maximum
        run_case(16'h0062, 4'd3, 16'h0008, 16'h4000, 16'h7773, 16'h0000);
        // R9 wide maximum, recover on third try
        run_case(16'h0043, 4'd15, 16'h0, 16'h4000, 16'h0F0F, 16'h0008);

        for (int n = 0; n < 60; n++) begin
            logic [15:0] fl, vc, st, li;
            logic [3:0]  sl;
            bit   [15:0] pl;
            logic [3:0]  ty;
            case ($urandom % 4)
                0: ty = 4'd4;
                1: ty = 4'd6;
                2: ty = 4'd8;
                default: ty = 4'($urandom);
            endcase
            fl = {8'($urandom), ty, 4'($urandom % 4)};
            sl = 4'($urandom % 6);
            vc = ($urandom % 2) ? 16'h0 : 16'($urandom);
            st = 16'($urandom);
            if ($urandom % 4 != 0) begin st[14] = 1'b1; st[13] = 1'b0; end
            li = 16'($urandom);
            pl = '0;
            for (int b = 0; b < 16; b++) pl[b] = ($urandom % 4 == 0);
            run_case(fl, sl, vc, st, li, pl);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule